// File: doc/BRIEF.md
# Register Rename Stage with Idiom and Move Elimination

This block maps the architectural destinations of a group of up to four uops onto physical register tags in one cycle. Each lane carries an operation kind, an operand size and two architectural register numbers (`rd`, `rb`). The block returns the physical tags for each lane's sources and destination, together with three flags: the uop was removed at rename, the uop depends on no earlier value, and a byte write needs a merge.

Two classes of uop never reach an execution unit. The first is a zeroing idiom. These are mapped onto a hardwired zero tag (tag 0), so they take no physical register. The second is a register-to-register move, which copies the source mapping. A per-physical-register reference count returns a tag to the free pool once no architectural register maps to it. The free pool is the set of tags whose count is zero.

Each architectural register also carries a flag that says its upper bits are known to be zero. A byte write to such a register needs no merge with the old value. A flush clears every flag and drops the group presented in that cycle. When the free pool cannot supply a tag for every allocating lane, the whole group stalls.

Top module: `rn_alias_table`

## Requirements
- R1: Kind 2 (XOR) with `rd==rb` and an operand size other than 3 (64-bit) is a zeroing idiom. Kind 3 (SUB) with `rd==rb` is a zeroing idiom while `sub_idiom_en_i` is 1. A zeroing idiom reports destination tag 0, both source tags 0, eliminated=1 and dependency-free=1, and consumes no tag.
- R2: XOR with `rd==rb` at size 3 is an ordinary dependent operation. It takes a fresh tag, and both of its sources report the current mapping of `rd`.
- R3: SUB with `rd==rb` while `sub_idiom_en_i` is 0 takes a fresh tag and reads the current mapping of `rd` on both sources. Kind 4 (AND with immediate zero) is never an idiom: it takes a fresh tag, source A is the mapping of `rd`, and it is neither eliminated nor dependency-free.
- R4: Kind 5 (move `rd<=rb`) is eliminated. Its destination tag and source A both equal the current mapping of `rb`, and its upper-zero flag is copied from `rb`.
- R5: A source in a lane that names a register written by an earlier lane of the same group receives the tag that the earlier lane assigned. This holds for kind 1 (ADD, `rd<=rd op rb`) and for every other kind.
- R6: Kind 6 (move immediate) takes a fresh tag, reads no source (both source tags 0) and is dependency-free. Fresh tags are the lowest-numbered free tags, handed out in lane order.
- R7: If the allocating lanes of a group outnumber the free tags, `in_ready_o` is 0 and no lane of the group is renamed. No output is valid the next cycle, and no mapping changes.
- R8: A tag returns to the free pool in the cycle after the last architectural mapping to it is replaced, and it can then be allocated again.
- R9: Kind 7 (byte write into `rd` from `rb`) takes a fresh tag and keeps the upper-zero flag of `rd`. If that flag is set, merge=0 and source A is tag 0. Otherwise merge=1 and source A is the mapping of `rd`. A zeroing idiom sets the flag, and any other allocating write clears it.
- R10: `flush_i` clears every upper-zero flag. The group presented in that cycle is not renamed and yields no valid output.
- R11: After reset every architectural register maps to tag 0 with its upper-zero flag set, every nonzero tag is free, and no output is valid.
- R12: The results of an accepted group appear on the outputs in the cycle after acceptance, with `out_valid_o` equal to the accepted `in_valid_i`. Kind 0 (no-op) and invalid lanes report all-zero tags and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Serialising event: clear upper-zero flags, drop this group |
| sub_idiom_en_i | input | 1 | Allow SUB same,same as a zeroing idiom |
| in_valid_i | input | LANES | Lane valid |
| in_kind_i | input | 3*LANES | Operation kind per lane (0 NOP, 1 ADD, 2 XOR, 3 SUB, 4 ANDI, 5 MOVR, 6 MOVI, 7 BYTE) |
| in_size_i | input | 2*LANES | Operand size per lane (0=8, 1=16, 2=32, 3=64 bit) |
| in_rd_i | input | AW*LANES | Destination (and first source) architectural register |
| in_rb_i | input | AW*LANES | Second source architectural register |
| in_ready_o | output | 1 | Group accepted this cycle (no tag shortage) |
| out_valid_o | output | LANES | Renamed lane valid |
| out_dst_o | output | PW*LANES | Destination physical tag |
| out_srca_o | output | PW*LANES | Source A physical tag |
| out_srcb_o | output | PW*LANES | Source B physical tag |
| out_elim_o | output | LANES | Uop completed at rename |
| out_depfree_o | output | LANES | Uop depends on no prior value |
| out_merge_o | output | LANES | Byte write needs a merge with the old value |

## Verification
The bench targets groups in which the same register is written several times or read right after an earlier lane writes it. A design that reads only the start-of-cycle table would hand stale tags to dependents and leak reference counts. It sweeps XOR and SUB at every operand size with `sub_idiom_en_i` in both states. A design that misclassifies an idiom would either waste a tag or break a real dependency on the old value. It fills the table until a four-way allocation cannot be met and then frees tags through idioms. This exposes a partial rename on stall and tags that are never recycled. Byte writes around moves and flushes check that the upper-zero flag travels with moves and dies on a flush, since a wrong flag drops a needed merge.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [2:0] {
        K_NOP  = 3'd0,
        K_ADD  = 3'd1,
        K_XOR  = 3'd2,
        K_SUB  = 3'd3,
        K_ANDI = 3'd4,
        K_MOVR = 3'd5,
        K_MOVI = 3'd6,
        K_BYTE = 3'd7
    } kind_e;

    localparam logic [1:0] SZ_64 = 2'd3;

    // Per-lane classification produced ahead of the rename walk
    typedef struct packed {
        logic writes;    // lane updates the map for rd
        logic is_idiom;  // zeroing idiom, mapped onto tag 0
        logic is_move;   // register move, mapping copied
        logic allocs;    // needs a fresh tag from the pool
        logic reads_rd;  // source A is the old rd
        logic reads_rb;  // source B is rb
        logic byte_wr;   // partial write, may need a merge
    } uop_class_t;

endpackage

// File: rtl/rn_uop_classify.sv
module rn_uop_classify
    import rn_pkg::*;
#(
    parameter int AW          = 4,
    parameter bit XOR64_IDIOM = 1'b0
) (
    input  logic          valid_i,
    input  logic [2:0]    kind_i,
    input  logic [1:0]    size_i,
    input  logic [AW-1:0] rd_i,
    input  logic [AW-1:0] rb_i,
    input  logic          sub_en_i,
    output uop_class_t    cls_o
);

    logic same_reg;
    logic xor_size_ok;

    assign same_reg    = (rd_i == rb_i);
    assign xor_size_ok = (size_i != SZ_64) || XOR64_IDIOM;

    always_comb begin
        cls_o = '0;
        if (valid_i) begin
            case (kind_e'(kind_i))
                K_ADD: begin
                    cls_o.writes = 1'b1; cls_o.allocs = 1'b1;
                    cls_o.reads_rd = 1'b1; cls_o.reads_rb = 1'b1;
                end
                K_XOR, K_SUB: begin
                    cls_o.writes = 1'b1;
                    if (same_reg && ((kind_e'(kind_i) == K_XOR) ? xor_size_ok : sub_en_i)) begin
                        cls_o.is_idiom = 1'b1;
                    end else begin
                        cls_o.allocs = 1'b1;
                        cls_o.reads_rd = 1'b1; cls_o.reads_rb = 1'b1;
                    end
                end
                K_ANDI: begin
                    cls_o.writes = 1'b1; cls_o.allocs = 1'b1;
                    cls_o.reads_rd = 1'b1;
                end
                K_MOVR: begin
                    cls_o.writes = 1'b1; cls_o.is_move = 1'b1;
                    cls_o.reads_rb = 1'b1;
                end
                K_MOVI: begin
                    cls_o.writes = 1'b1; cls_o.allocs = 1'b1;
                end
                K_BYTE: begin
                    cls_o.writes = 1'b1; cls_o.allocs = 1'b1;
                    cls_o.reads_rd = 1'b1; cls_o.reads_rb = 1'b1;
                    cls_o.byte_wr = 1'b1;
                end
                default: cls_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/rn_tag_pick.sv
module rn_tag_pick #(
    parameter int NUM_PHYS = 64,
    parameter int PICKS    = 4,
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic [NUM_PHYS-1:0]          free_i,
    output logic [PICKS-1:0][PW-1:0]     tag_o,
    output logic [PICKS-1:0]             ok_o
);

    logic [NUM_PHYS-1:0] taken;
    logic                got;

    // k-th pick is the k-th lowest free tag
    always_comb begin
        taken = '0;
        tag_o = '0;
        ok_o  = '0;
        got   = 1'b0;
        for (int k = 0; k < PICKS; k++) begin
            got = 1'b0;
            for (int t = 0; t < NUM_PHYS; t++) begin
                if (!got && free_i[t] && !taken[t]) begin
                    tag_o[k] = PW'(t);
                    ok_o[k]  = 1'b1;
                    taken[t] = 1'b1;
                    got      = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table
    import rn_pkg::*;
#(
    parameter int NUM_ARCH    = 16,
    parameter int NUM_PHYS    = 64,
    parameter int LANES       = 4,
    parameter bit XOR64_IDIOM = 1'b0,
    localparam int AW         = $clog2(NUM_ARCH),
    localparam int PW         = $clog2(NUM_PHYS)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  flush_i,
    input  logic                  sub_idiom_en_i,
    input  logic [LANES-1:0]      in_valid_i,
    input  logic [LANES*3-1:0]    in_kind_i,
    input  logic [LANES*2-1:0]    in_size_i,
    input  logic [LANES*AW-1:0]   in_rd_i,
    input  logic [LANES*AW-1:0]   in_rb_i,
    output logic                  in_ready_o,
    output logic [LANES-1:0]      out_valid_o,
    output logic [LANES*PW-1:0]   out_dst_o,
    output logic [LANES*PW-1:0]   out_srca_o,
    output logic [LANES*PW-1:0]   out_srcb_o,
    output logic [LANES-1:0]      out_elim_o,
    output logic [LANES-1:0]      out_depfree_o,
    output logic [LANES-1:0]      out_merge_o
);

    localparam int CW = $clog2(NUM_ARCH + 1);
    localparam int LW = $clog2(LANES);

    typedef struct packed {
        logic [NUM_ARCH-1:0][PW-1:0] map;
        logic [NUM_PHYS-1:0][CW-1:0] cnt;
        logic [NUM_ARCH-1:0]         uz;
        logic [LANES-1:0]            vld;
        logic [LANES-1:0][PW-1:0]    dst;
        logic [LANES-1:0][PW-1:0]    sa;
        logic [LANES-1:0][PW-1:0]    sb;
        logic [LANES-1:0]            elim;
        logic [LANES-1:0]            df;
        logic [LANES-1:0]            mg;
    } st_t;

    st_t s_q, s_d, walk;

    uop_class_t                cls [LANES];
    logic [NUM_PHYS-1:0]       free_vec;
    logic [LANES-1:0][PW-1:0]  pick_tag;
    logic [LANES-1:0]          pick_ok;
    logic                      stall;

    logic [AW-1:0] rd_l, rb_l;
    logic [PW-1:0] t_rd, t_rb, t_new;
    logic          uz_new;
    logic [LW:0]   rk;

    // ---------------------------------------------------------------
    // Lane classification
    // ---------------------------------------------------------------
    for (genvar l = 0; l < LANES; l++) begin : g_cls
        rn_uop_classify #(.AW(AW), .XOR64_IDIOM(XOR64_IDIOM)) cls_i (
            .valid_i  (in_valid_i[l]),
            .kind_i   (in_kind_i[l*3 +: 3]),
            .size_i   (in_size_i[l*2 +: 2]),
            .rd_i     (in_rd_i[l*AW +: AW]),
            .rb_i     (in_rb_i[l*AW +: AW]),
            .sub_en_i (sub_idiom_en_i),
            .cls_o    (cls[l])
        );
    end

    // Free pool: nonzero tags with no architectural reference
    always_comb begin
        for (int t = 0; t < NUM_PHYS; t++) begin
            free_vec[t] = (t != 0) && (s_q.cnt[t] == '0);
        end
    end

    rn_tag_pick #(.NUM_PHYS(NUM_PHYS), .PICKS(LANES)) pick_i (
        .free_i (free_vec),
        .tag_o  (pick_tag),
        .ok_o   (pick_ok)
    );

    // ---------------------------------------------------------------
    // Sequential walk over the lanes against a working copy of the map
    // ---------------------------------------------------------------
    always_comb begin
        walk      = s_q;
        walk.vld  = '0;
        walk.dst  = '0;
        walk.sa   = '0;
        walk.sb   = '0;
        walk.elim = '0;
        walk.df   = '0;
        walk.mg   = '0;
        stall     = 1'b0;
        rk        = '0;
        rd_l      = '0;
        rb_l      = '0;
        t_rd      = '0;
        t_rb      = '0;
        t_new     = '0;
        uz_new    = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            rd_l   = in_rd_i[l*AW +: AW];
            rb_l   = in_rb_i[l*AW +: AW];
            t_rd   = walk.map[rd_l];
            t_rb   = walk.map[rb_l];
            t_new  = '0;
            uz_new = 1'b0;
            walk.vld[l] = in_valid_i[l];
            if (cls[l].is_idiom) begin
                walk.elim[l] = 1'b1;
                walk.df[l]   = 1'b1;
                uz_new       = 1'b1;
            end else if (cls[l].is_move) begin
                t_new        = t_rb;
                walk.elim[l] = 1'b1;
                walk.sa[l]   = t_rb;
                uz_new       = walk.uz[rb_l];
            end else if (cls[l].allocs) begin
                if (!pick_ok[rk[LW-1:0]]) begin
                    stall = 1'b1;
                end
                t_new      = pick_tag[rk[LW-1:0]];
                rk         = rk + 1'b1;
                walk.df[l] = !cls[l].reads_rd && !cls[l].reads_rb;
                walk.sa[l] = cls[l].reads_rd ? t_rd : '0;
                walk.sb[l] = cls[l].reads_rb ? t_rb : '0;
                if (cls[l].byte_wr) begin
                    uz_new     = walk.uz[rd_l];
                    walk.mg[l] = !walk.uz[rd_l];
                    if (walk.uz[rd_l]) begin
                        walk.sa[l] = '0;
                    end
                end
            end
            if (cls[l].writes) begin
                if (t_rd != '0) begin
                    walk.cnt[t_rd] = walk.cnt[t_rd] - 1'b1;
                end
                if (t_new != '0) begin
                    walk.cnt[t_new] = walk.cnt[t_new] + 1'b1;
                end
                walk.map[rd_l] = t_new;
                walk.uz[rd_l]  = uz_new;
                walk.dst[l]    = t_new;
            end
        end
    end

    // Commit selection: flush and stall keep the table untouched
    always_comb begin
        s_d = walk;
        if (flush_i || stall) begin
            s_d      = s_q;
            s_d.vld  = '0;
            s_d.dst  = '0;
            s_d.sa   = '0;
            s_d.sb   = '0;
            s_d.elim = '0;
            s_d.df   = '0;
            s_d.mg   = '0;
            if (flush_i) begin
                s_d.uz = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.uz <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    assign in_ready_o    = !stall;
    assign out_valid_o   = s_q.vld;
    assign out_elim_o    = s_q.elim;
    assign out_depfree_o = s_q.df;
    assign out_merge_o   = s_q.mg;

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign out_dst_o[l*PW +: PW]  = s_q.dst[l];
        assign out_srca_o[l*PW +: PW] = s_q.sa[l];
        assign out_srcb_o[l*PW +: PW] = s_q.sb[l];
    end

endmodule

// File: rtl/rn_alias_table_chk.sv
module rn_alias_table_chk #(
    parameter int LANES = 4,
    parameter int AW    = 4,
    parameter int PW    = 6,
    parameter bit XOR64 = 1'b0
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                flush_i,
    input logic                in_ready_o,
    input logic [LANES-1:0]    in_valid_i,
    input logic [LANES*3-1:0]  in_kind_i,
    input logic [LANES*2-1:0]  in_size_i,
    input logic [LANES*AW-1:0] in_rd_i,
    input logic [LANES*AW-1:0] in_rb_i,
    input logic [LANES-1:0]    out_valid_o,
    input logic [LANES*PW-1:0] out_dst_o,
    input logic [LANES*PW-1:0] out_srca_o,
    input logic [LANES-1:0]    out_elim_o,
    input logic [LANES-1:0]    out_depfree_o
);

    logic acc;
    assign acc = in_ready_o && !flush_i;

    a_r7_stall_drops_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_ready_o && !flush_i) |=> (out_valid_o == '0));

    a_r10_flush_drops_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (out_valid_o == '0));

    a_r12_valid_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> (out_valid_o == $past(in_valid_i)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [2:0]    k;
        logic [1:0]    sz;
        logic          same;
        logic [PW-1:0] dst, sra;
        assign k    = in_kind_i[l*3 +: 3];
        assign sz   = in_size_i[l*2 +: 2];
        assign same = (in_rd_i[l*AW +: AW] == in_rb_i[l*AW +: AW]);
        assign dst  = out_dst_o[l*PW +: PW];
        assign sra  = out_srca_o[l*PW +: PW];

        a_r1_xor_idiom_zero_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (acc && in_valid_i[l] && k == 3'd2 && same && (sz != 2'd3 || XOR64))
            |=> (out_valid_o[l] && dst == '0 && out_elim_o[l] && out_depfree_o[l]));

        a_r3_andi_keeps_dep: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (acc && in_valid_i[l] && k == 3'd4)
            |=> (!out_elim_o[l] && !out_depfree_o[l] && dst != '0));

        a_r4_move_copies_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (acc && in_valid_i[l] && k == 3'd5)
            |=> (out_elim_o[l] && !out_depfree_o[l] && dst == sra));

        a_r6_movi_fresh_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (acc && in_valid_i[l] && k == 3'd6)
            |=> (dst != '0 && out_depfree_o[l] && !out_elim_o[l]));
    end

endmodule

bind rn_alias_table rn_alias_table_chk #(
    .LANES (LANES),
    .AW    (AW),
    .PW    (PW),
    .XOR64 (XOR64_IDIOM)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .in_ready_o    (in_ready_o),
    .in_valid_i    (in_valid_i),
    .in_kind_i     (in_kind_i),
    .in_size_i     (in_size_i),
    .in_rd_i       (in_rd_i),
    .in_rb_i       (in_rb_i),
    .out_valid_o   (out_valid_o),
    .out_dst_o     (out_dst_o),
    .out_srca_o    (out_srca_o),
    .out_elim_o    (out_elim_o),
    .out_depfree_o (out_depfree_o)
);

// File: tb/rn_alias_table_tb_top.sv
`timescale 1ns/1ps
module rn_alias_table_tb_top;

    localparam int NA = 16;
    localparam int NP = 20;
    localparam int L  = 4;
    localparam int AW = 4;
    localparam int PW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic sub_en = 1'b0;
    logic [L-1:0]    in_valid = '0;
    logic [L*3-1:0]  in_kind = '0;
    logic [L*2-1:0]  in_size = '0;
    logic [L*AW-1:0] in_rd = '0;
    logic [L*AW-1:0] in_rb = '0;
    logic            in_ready;
    logic [L-1:0]    out_valid;
    logic [L*PW-1:0] out_dst, out_sa, out_sb;
    logic [L-1:0]    out_elim, out_df, out_mg;

    always #4 clk = ~clk;

    rn_alias_table #(.NUM_ARCH(NA), .NUM_PHYS(NP), .LANES(L)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .sub_idiom_en_i(sub_en),
        .in_valid_i(in_valid), .in_kind_i(in_kind), .in_size_i(in_size),
        .in_rd_i(in_rd), .in_rb_i(in_rb), .in_ready_o(in_ready),
        .out_valid_o(out_valid), .out_dst_o(out_dst), .out_srca_o(out_sa),
        .out_srcb_o(out_sb), .out_elim_o(out_elim), .out_depfree_o(out_df),
        .out_merge_o(out_mg)
    );

    int errors = 0;
    int checks = 0;

    // stimulus for the next group
    bit s_vld[L]; int s_kind[L]; int s_size[L]; int s_rd[L]; int s_rb[L];
    bit s_flush; bit s_sub;

    // behavioural model state
    int mmap[NA]; int mcnt[NP]; bit mflag[NA];
    bit e_vld[L]; int e_dst[L]; int e_sa[L]; int e_sb[L];
    bit e_elim[L]; bit e_df[L]; bit e_mg[L]; string e_tag[L];

    task automatic expect_eq(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_group();
        for (int l = 0; l < L; l++) begin
            s_vld[l] = 0; s_kind[l] = 0; s_size[l] = 2; s_rd[l] = 0; s_rb[l] = 0;
        end
        s_flush = 0;
    endtask

    task automatic set_lane(int l, int k, int sz, int rd, int rb);
        s_vld[l] = 1; s_kind[l] = k; s_size[l] = sz; s_rd[l] = rd; s_rb[l] = rb;
    endtask

    task automatic model_step(output bit rdy);
        int fl[$];
        int need, pi, trd, trb, nt, k;
        bit idi[L]; bit al[L]; bit wr, nuz;
        for (int t = 1; t < NP; t++) if (mcnt[t] == 0) fl.push_back(t);
        need = 0;
        for (int l = 0; l < L; l++) begin
            idi[l] = 0; al[l] = 0;
            if (s_vld[l]) begin
                k = s_kind[l];
                idi[l] = (k == 2 && s_rd[l] == s_rb[l] && s_size[l] != 3) ||
                         (k == 3 && s_rd[l] == s_rb[l] && s_sub);
                al[l] = !idi[l] && (k != 0) && (k != 5);
                if (al[l]) need++;
            end
        end
        rdy = (need <= fl.size());
        for (int l = 0; l < L; l++) begin
            e_vld[l] = 0; e_dst[l] = 0; e_sa[l] = 0; e_sb[l] = 0;
            e_elim[l] = 0; e_df[l] = 0; e_mg[l] = 0; e_tag[l] = "R12";
        end
        if (s_flush) begin
            for (int r = 0; r < NA; r++) mflag[r] = 0;
            for (int l = 0; l < L; l++) e_tag[l] = "R10";
            return;
        end
        if (!rdy) begin
            for (int l = 0; l < L; l++) e_tag[l] = "R7";
            return;
        end
        pi = 0;
        for (int l = 0; l < L; l++) begin
            if (s_vld[l]) begin
                e_vld[l] = 1;
                k = s_kind[l];
                trd = mmap[s_rd[l]]; trb = mmap[s_rb[l]];
                wr = 1; nt = 0; nuz = 0;
                if (idi[l]) begin
                    e_elim[l] = 1; e_df[l] = 1; nuz = 1; e_tag[l] = "R1";
                end else begin
                    case (k)
                        0: begin wr = 0; e_tag[l] = "R12"; end
                        5: begin nt = trb; e_elim[l] = 1; e_sa[l] = trb;
                                 nuz = mflag[s_rb[l]]; e_tag[l] = "R4"; end
                        6: begin nt = fl[pi]; pi++; e_df[l] = 1; e_tag[l] = "R6"; end
                        7: begin nt = fl[pi]; pi++; e_sb[l] = trb;
                                 nuz = mflag[s_rd[l]];
                                 e_sa[l] = nuz ? 0 : trd; e_mg[l] = !nuz;
                                 e_tag[l] = "R9"; end
                        4: begin nt = fl[pi]; pi++; e_sa[l] = trd; e_tag[l] = "R3"; end
                        default: begin
                            nt = fl[pi]; pi++; e_sa[l] = trd; e_sb[l] = trb;
                            e_tag[l] = (k == 1) ? "R5" : (k == 2) ? "R2" : "R3";
                        end
                    endcase
                end
                if (wr) begin
                    if (trd != 0) mcnt[trd]--;
                    if (nt != 0) mcnt[nt]++;
                    mmap[s_rd[l]] = nt; mflag[s_rd[l]] = nuz; e_dst[l] = nt;
                end
            end
        end
    endtask

    task automatic compare_out();
        for (int l = 0; l < L; l++) begin
            int gd, ga, gb;
            gd = int'(out_dst[l*PW +: PW]);
            ga = int'(out_sa[l*PW +: PW]);
            gb = int'(out_sb[l*PW +: PW]);
            checks++;
            if (out_valid[l] !== e_vld[l] || gd != e_dst[l] || ga != e_sa[l] ||
                gb != e_sb[l] || out_elim[l] !== e_elim[l] ||
                out_df[l] !== e_df[l] || out_mg[l] !== e_mg[l]) begin
                errors++;
                $display("FAIL %s lane %0d: got v=%0b d=%0d a=%0d b=%0d el=%0b df=%0b mg=%0b expected v=%0b d=%0d a=%0d b=%0d el=%0b df=%0b mg=%0b",
                    e_tag[l], l, out_valid[l], gd, ga, gb, out_elim[l], out_df[l], out_mg[l],
                    e_vld[l], e_dst[l], e_sa[l], e_sb[l], e_elim[l], e_df[l], e_mg[l]);
            end
        end
    endtask

    task automatic tick();
        bit rdy;
        @(negedge clk);
        compare_out();
        flush = s_flush; sub_en = s_sub;
        for (int l = 0; l < L; l++) begin
            in_valid[l]          = s_vld[l];
            in_kind[l*3 +: 3]    = 3'(s_kind[l]);
            in_size[l*2 +: 2]    = 2'(s_size[l]);
            in_rd[l*AW +: AW]    = AW'(s_rd[l]);
            in_rb[l*AW +: AW]    = AW'(s_rb[l]);
        end
        #1;
        model_step(rdy);
        checks++;
        if (in_ready !== rdy) begin
            errors++;
            $display("FAIL R7 ready: got %0b expected %0b", in_ready, rdy);
        end
    endtask

    bit done = 0;

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NA; r++) begin mmap[r] = 0; mflag[r] = 1; end
        for (int t = 0; t < NP; t++) mcnt[t] = 0;
        for (int l = 0; l < L; l++) begin
            e_vld[l] = 0; e_dst[l] = 0; e_sa[l] = 0; e_sb[l] = 0;
            e_elim[l] = 0; e_df[l] = 0; e_mg[l] = 0; e_tag[l] = "R11";
        end
        clear_group();
        s_sub = 0;
        repeat (3) @(negedge clk);
        expect_eq("R11 valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R11: fresh tags after reset are the lowest ones, in lane order
        clear_group();
        for (int l = 0; l < L; l++) set_lane(l, 6, 3, l, 0);
        tick();
        // R5 intra-group: movi r5, movi r6, add r5,r6, move r7<-r5
        clear_group();
        set_lane(0, 6, 3, 5, 0); set_lane(1, 6, 3, 6, 0);
        set_lane(2, 1, 3, 5, 6); set_lane(3, 5, 3, 7, 5);
        tick();
        expect_eq("R11 first tag lane3", int'(out_dst[3*PW +: PW]), 4);
        // R1, R2, R3 idiom classification
        clear_group();
        set_lane(0, 2, 2, 1, 1); set_lane(1, 2, 3, 2, 2);
        set_lane(2, 3, 2, 3, 3); set_lane(3, 4, 2, 4, 4);
        tick();
        expect_eq("R5 add srcb is lane1 tag", int'(out_sb[2*PW +: PW]),
                  int'(out_dst[1*PW +: PW]));
        expect_eq("R4 move takes lane2 tag", int'(out_dst[3*PW +: PW]),
                  int'(out_dst[2*PW +: PW]));
        clear_group(); s_sub = 1;
        set_lane(0, 3, 3, 8, 8); set_lane(1, 3, 1, 9, 9);
        tick();
        expect_eq("R1 xor32 dst tag", int'(out_dst[0 +: PW]), 0);
        expect_eq("R2 xor64 not eliminated", int'(out_elim[1]), 0);
        expect_eq("R3 sub without enable not eliminated", int'(out_elim[2]), 0);
        expect_eq("R3 andi not dep-free", int'(out_df[3]), 0);
        // R9 byte writes and flag through a move
        clear_group(); s_sub = 0;
        set_lane(0, 7, 0, 1, 2); set_lane(1, 7, 0, 2, 3);
        set_lane(2, 5, 3, 10, 8); set_lane(3, 7, 0, 10, 1);
        tick();
        expect_eq("R1 sub idiom when enabled", int'(out_elim[0]), 1);
        clear_group();
        tick();
        expect_eq("R9 byte on zeroed reg merge", int'(out_mg[0]), 0);
        expect_eq("R9 byte on dirty reg merge", int'(out_mg[1]), 1);
        expect_eq("R9 byte after flag-copying move", int'(out_mg[3]), 0);
        // R10 flush clears flags and drops the group
        clear_group(); set_lane(0, 2, 2, 11, 11); tick();
        clear_group(); s_flush = 1; set_lane(0, 6, 3, 12, 0); tick();
        clear_group(); set_lane(0, 7, 0, 11, 0); tick();
        expect_eq("R10 flushed group not valid", int'(out_valid), 0);
        clear_group(); tick();
        expect_eq("R10 flag cleared by flush", int'(out_mg[0]), 1);
        // R7 / R8 tag exhaustion and recycling
        for (int g = 0; g < 4; g++) begin
            clear_group();
            for (int l = 0; l < L; l++) set_lane(l, 2, 2, g*4 + l, g*4 + l);
            tick();
        end
        for (int g = 0; g < 4; g++) begin
            clear_group();
            for (int l = 0; l < L; l++) set_lane(l, 6, 3, g*4 + l, 0);
            tick();
        end
        clear_group();
        for (int l = 0; l < L; l++) set_lane(l, 6, 3, l, 0);
        tick();
        expect_eq("R7 stall with three free tags", int'(in_ready), 0);
        clear_group(); set_lane(0, 2, 2, 14, 14); set_lane(1, 2, 2, 15, 15);
        tick();
        clear_group();
        for (int l = 0; l < L; l++) set_lane(l, 6, 3, l, 0);
        tick();
        expect_eq("R8 recycled tags end the stall", int'(in_ready), 1);

        // mixed traffic
        for (int c = 0; c < 3000; c++) begin
            clear_group();
            s_sub = 1'($urandom_range(0, 1));
            s_flush = ($urandom_range(0, 99) < 3);
            for (int l = 0; l < L; l++) begin
                if ($urandom_range(0, 9) < 8) begin
                    int rd, rb;
                    rd = $urandom_range(0, NA-1);
                    rb = ($urandom_range(0, 9) < 3) ? rd : $urandom_range(0, NA-1);
                    set_lane(l, $urandom_range(0, 7), $urandom_range(0, 3), rd, rb);
                end
            end
            tick();
        end
        clear_group(); tick(); tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule